// File: doc/BRIEF.md
# Elastic Transmit Buffer with Hysteresis Flow Control

This block sits between a host serial receiver and the logic that consumes the host's characters. Each received byte goes into a small front FIFO. The front FIFO moves its head into a large elastic store whenever that store has room. The consumer reads the elastic store through a show-ahead port: the head byte and a valid flag are always visible, and a read request pops the head.

An active-low clear-to-send output tells the host when to pause. It uses two thresholds on the elastic store's occupancy with a dead band between them, so it does not toggle on every character near one threshold. When software flow control is enabled, every change of clear-to-send also raises a one-cycle request carrying the matching pause or resume character code, for a transmitter to send. A byte that arrives while the front FIFO is full is lost. The loss is recorded in a sticky flag that a separate input clears.

Top module: `tx_elastic_buf`

## Requirements
- R1: After reset, rd_valid_o, cts_no, ovf_o and flow_req_o are all 0.
- R2: Bytes leave at rd_data_o in the order they were written. rd_data_o is the oldest stored byte whenever rd_valid_o is 1. rd_req_i removes it at the next edge, and rd_req_i has no effect while rd_valid_o is 0.
- R3: A byte written into an empty block sets rd_valid_o after the second rising edge: the first edge stores it in the front FIFO and the second moves it into the elastic store. At most one byte moves per cycle, and only while the elastic store is not full.
- R4: The front FIFO holds FRONT_DEPTH (default 14) bytes. A write made while it holds FRONT_DEPTH bytes is discarded, even if a byte leaves the FIFO in the same cycle.
- R5: The elastic store holds EL_DEPTH (default 1024) bytes. With both stores full, exactly EL_DEPTH + FRONT_DEPTH bytes can be read out.
- R6: cts_no becomes 1 at the edge after elastic occupancy is at least HI_MARK (default 796).
- R7: cts_no becomes 0 at the edge after elastic occupancy is below LO_MARK (default 128). While occupancy is in [LO_MARK, HI_MARK), cts_no keeps its value.
- R8: ovf_o is set at the edge after a write is discarded and stays set until an ovf_clr_i cycle with no discard. If a discard and a clear fall in the same cycle, the flag is set.
- R9: When swfc_en_i is 1 in the cycle before cts_no changes, flow_req_o is 1 for exactly the cycle in which cts_no has its new value. flow_code_o is 8'h13 while cts_no is 1 and 8'h11 while cts_no is 0.
- R10: When swfc_en_i is 0 at the edge where cts_no changes, flow_req_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write strobe for a received byte |
| wr_data_i | input | DATA_W | Received byte |
| rd_req_i | input | 1 | Pop request from the consumer |
| rd_valid_o | output | 1 | Elastic store not empty |
| rd_data_o | output | DATA_W | Oldest stored byte |
| cts_no | output | 1 | Clear-to-send, active low |
| swfc_en_i | input | 1 | Enables pause/resume character requests |
| flow_req_o | output | 1 | One-cycle pause/resume request |
| flow_code_o | output | 8 | Pause (0x13) or resume (0x11) code |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| ovf_o | output | 1 | Sticky flag for a discarded write |

## Verification
The bench builds the block with its default parameters: 14 front entries, 1024 elastic entries and thresholds of 796 and 128. With these values a filling run of about a thousand cycles carries occupancy across both thresholds and into the full condition of both stores. Discards, clear-to-send transitions and the dead band between the thresholds are therefore all reached at their real sizes, within a few thousand cycles per phase.

// File: rtl/txeb_pkg.sv
package txeb_pkg;
  localparam int unsigned CODE_W = 8;
  localparam logic [CODE_W-1:0] RESUME_CODE = 8'h11;
  localparam logic [CODE_W-1:0] PAUSE_CODE  = 8'h13;
endpackage

// File: rtl/txeb_fifo.sv
module txeb_fifo #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 14,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CW-1:0]     count_o,
  output logic              full_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/txeb_flow.sv
module txeb_flow
  import txeb_pkg::*;
#(
  parameter int unsigned CW      = 11,
  parameter int unsigned HI_MARK = 796,
  parameter int unsigned LO_MARK = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     occ_i,
  input  logic              swfc_en_i,
  output logic              cts_no,
  output logic              req_o,
  output logic [CODE_W-1:0] code_o
);
  logic cts_q, cts_d, req_q;

  // dead band between the marks keeps the previous state
  always_comb begin
    cts_d = cts_q;
    if (occ_i >= CW'(HI_MARK))     cts_d = 1'b1;
    else if (occ_i < CW'(LO_MARK)) cts_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cts_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      cts_q <= cts_d;
      req_q <= swfc_en_i && (cts_d != cts_q);
    end
  end

  assign cts_no = cts_q;
  assign req_o  = req_q;
  assign code_o = cts_q ? PAUSE_CODE : RESUME_CODE;
endmodule

// File: rtl/tx_elastic_buf.sv
module tx_elastic_buf
  import txeb_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned FRONT_DEPTH = 14,
  parameter int unsigned EL_DEPTH    = 1024,
  parameter int unsigned HI_MARK     = 796,
  parameter int unsigned LO_MARK     = 128,
  localparam int unsigned FR_CW = $clog2(FRONT_DEPTH + 1),
  localparam int unsigned EL_CW = $clog2(EL_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_req_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cts_no,
  input  logic              swfc_en_i,
  output logic              flow_req_o,
  output logic [CODE_W-1:0] flow_code_o,
  input  logic              ovf_clr_i,
  output logic              ovf_o
);
  logic [DATA_W-1:0] front_data;
  logic [FR_CW-1:0]  front_cnt;
  logic front_full, front_empty;
  logic [EL_CW-1:0]  el_cnt;
  logic el_full, el_empty;
  logic xfer, wr_drop, ovf_q;

  assign xfer    = !front_empty && !el_full;
  assign wr_drop = wr_valid_i && front_full;

  txeb_fifo #(.DATA_W(DATA_W), .DEPTH(FRONT_DEPTH)) i_front (
    .clk_i, .rst_ni,
    .push_i(wr_valid_i), .data_i(wr_data_i),
    .pop_i(xfer), .data_o(front_data),
    .count_o(front_cnt), .full_o(front_full), .empty_o(front_empty)
  );

  txeb_fifo #(.DATA_W(DATA_W), .DEPTH(EL_DEPTH)) i_elastic (
    .clk_i, .rst_ni,
    .push_i(xfer), .data_i(front_data),
    .pop_i(rd_req_i), .data_o(rd_data_o),
    .count_o(el_cnt), .full_o(el_full), .empty_o(el_empty)
  );

  txeb_flow #(.CW(EL_CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) i_flow (
    .clk_i, .rst_ni,
    .occ_i(el_cnt), .swfc_en_i,
    .cts_no, .req_o(flow_req_o), .code_o(flow_code_o)
  );

  // a discard in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (wr_drop)   ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign ovf_o      = ovf_q;
  assign rd_valid_o = !el_empty;
endmodule

// File: rtl/txeb_chk.sv
module txeb_chk
  import txeb_pkg::*;
#(
  parameter int unsigned EL_CW   = 11,
  parameter int unsigned HI_MARK = 796,
  parameter int unsigned LO_MARK = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              front_full,
  input logic              ovf_clr_i,
  input logic              ovf_o,
  input logic [EL_CW-1:0]  el_cnt,
  input logic              cts_no,
  input logic              swfc_en_i,
  input logic              flow_req_o,
  input logic [CODE_W-1:0] flow_code_o
);
  // R6
  cts_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_cnt >= EL_CW'(HI_MARK)) |=> cts_no);
  // R7
  cts_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_cnt < EL_CW'(LO_MARK)) |=> !cts_no);
  // R7
  cts_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (el_cnt >= EL_CW'(LO_MARK) && el_cnt < EL_CW'(HI_MARK)) |=> (cts_no == $past(cts_no)));
  // R8
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && front_full) |=> ovf_o);
  // R8
  ovf_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_clr_i && !(wr_valid_i && front_full)) |=> !ovf_o);
  // R9
  pause_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cts_no) && $past(swfc_en_i)) |-> (flow_req_o && flow_code_o == PAUSE_CODE));
  // R9
  resume_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cts_no) && $past(swfc_en_i)) |-> (flow_req_o && flow_code_o == RESUME_CODE));
  // R10
  quiet_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(swfc_en_i) |-> !flow_req_o);
endmodule

bind tx_elastic_buf txeb_chk #(.EL_CW(EL_CW), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .front_full(front_full),
  .ovf_clr_i(ovf_clr_i), .ovf_o(ovf_o), .el_cnt(el_cnt), .cts_no(cts_no),
  .swfc_en_i(swfc_en_i), .flow_req_o(flow_req_o), .flow_code_o(flow_code_o)
);

// File: tb/test_tx_elastic_buf.sv
`timescale 1ns/1ps
module test_tx_elastic_buf;
  localparam int FD = 14;
  localparam int ED = 1024;
  localparam int HI = 796;
  localparam int LO = 128;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic wv = 1'b0, rr = 1'b0, sw = 1'b0, clr = 1'b0;
  logic [7:0] wd = '0;
  logic rd_valid_o, cts_no, flow_req_o, ovf_o;
  logic [7:0] rd_data_o, flow_code_o;

  int checks = 0;
  int fails = 0;
  int pops = 0;
  bit done = 0;

  logic [7:0] fq[$];
  logic [7:0] eq[$];
  logic m_cts = 0, m_req = 0, m_ovf = 0;

  always #2.5 clk_i = ~clk_i;

  tx_elastic_buf i_tx_elastic_buf (
    .clk_i, .rst_ni,
    .wr_valid_i(wv), .wr_data_i(wd), .rd_req_i(rr),
    .rd_valid_o, .rd_data_o, .cts_no,
    .swfc_en_i(sw), .flow_req_o, .flow_code_o,
    .ovf_clr_i(clr), .ovf_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic cts_next(input int occ, input logic cur);
    if (occ >= HI) return 1'b1;
    if (occ < LO) return 1'b0;
    return cur;
  endfunction

  function automatic logic [7:0] code_of(input logic c);
    return c ? 8'h13 : 8'h11;
  endfunction

  // one clock: model update with current inputs, then compare at the next negedge
  task automatic cyc();
    bit xfer, pop, acc;
    logic nc;
    if (rr && rd_valid_o) pops++;
    xfer = (fq.size() > 0) && (eq.size() < ED);
    pop  = rr && (eq.size() > 0);
    acc  = wv && (fq.size() < FD);
    nc   = cts_next(eq.size(), m_cts);
    m_req = sw && (nc != m_cts);
    m_cts = nc;
    if (wv && !acc) m_ovf = 1'b1;
    else if (clr) m_ovf = 1'b0;
    if (pop) void'(eq.pop_front());
    if (xfer) eq.push_back(fq.pop_front());
    if (acc) fq.push_back(wd);
    @(negedge clk_i);
    chk("R2 R3 rd_valid", rd_valid_o, eq.size() > 0);
    if (eq.size() > 0) chk("R2 rd_data", rd_data_o, eq[0]);
    chk("R6 R7 cts", cts_no, m_cts);
    chk("R8 ovf", ovf_o, m_ovf);
    chk("R9 R10 flow_req", flow_req_o, m_req);
    chk("R9 flow_code", flow_code_o, code_of(m_cts));
  endtask

  task automatic run(input int n, input int pw, input int pr, input bit seq);
    for (int i = 0; i < n; i++) begin
      wv = ($urandom_range(99) < pw);
      rr = ($urandom_range(99) < pr);
      wd = seq ? 8'(i) : 8'($urandom);
      cyc();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 150000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 rd_valid", rd_valid_o, 0);
    chk("R1 cts", cts_no, 0);
    chk("R1 ovf", ovf_o, 0);
    chk("R1 flow_req", flow_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    sw = 1'b1;

    // R3 two-edge latency from empty
    wv = 1; wd = 8'hA5; cyc();
    wv = 0;
    chk("R3 not yet valid", rd_valid_o, 0);
    cyc();
    chk("R3 valid after two edges", rd_valid_o, 1);
    chk("R3 data", rd_data_o, 8'hA5);
    rr = 1; cyc(); rr = 0;
    // R2 pop while empty is ignored
    rr = 1; cyc(); cyc(); rr = 0;
    chk("R2 empty stays empty", rd_valid_o, 0);

    run(3000, 50, 60, 0);
    run(40, 0, 100, 0);

    // fill both stores; R4 R5 discards once both are full
    pops = 0;
    clr = 0; rr = 0;
    for (int i = 0; i < 1100; i++) begin wv = 1; wd = 8'(i); cyc(); end
    chk("R6 cts high when full", cts_no, 1);
    chk("R8 ovf after discard", ovf_o, 1);
    // R8 set wins over clear
    wv = 1; clr = 1; cyc();
    chk("R8 set beats clear", ovf_o, 1);
    wv = 0; cyc();
    chk("R8 cleared", ovf_o, 0);
    clr = 0;

    // drain with software flow off, stays in dead band: R7 hold
    sw = 0; rr = 1;
    for (int i = 0; i < 600; i++) cyc();
    chk("R7 hold in band", cts_no, 1);
    sw = 1;
    for (int i = 0; i < 500; i++) cyc();
    rr = 0;
    chk("R4 R5 bytes delivered", pops, ED + FD);
    chk("R7 cts low when drained", cts_no, 0);

    // rising edge with software flow disabled: R10
    sw = 0;
    for (int i = 0; i < 900; i++) begin wv = 1; wd = 8'($urandom); cyc(); end
    wv = 0;
    chk("R10 cts high no request", cts_no, 1);
    sw = 1; rr = 1;
    for (int i = 0; i < 900; i++) cyc();
    rr = 0;

    for (int k = 0; k < 6; k++) begin
      sw = k[0];
      run(700, 70, 40, 1);
      run(700, 20, 80, 0);
    end
    finish_run();
  end
endmodule